// File: doc/BRIEF.md
# Scrambling NRZI Bit Serializer

This block turns a stream of 10-bit parallel words into a single serial line. It runs on a bit clock at ten times the word rate. A word is written into a holding register by a one-cycle load strobe. It is then shifted out least significant bit first, with one bit on each active bit-clock cycle. Before it leaves the block, each bit can pass through a self-synchronizing scrambler with the polynomial x^9 + x^4 + 1, which is used for serial digital video. The bit can also be recoded from level form (NRZ) to transition form (NRZI).

The scrambler and the NRZI coder have separate controls, so the block can act as a plain serializer, a video serializer, or any mix of the two. A lock input from the clock source gates all state: while the clock source is not locked, nothing advances and the line stays still. A flush input, driven when a new sync position is found, clears every register at the next edge. Bit-clock generation and the analog line driver lie outside this block.

Top module: `sdi_bit_serializer`

## Requirements
- R1: Each word leaves the block least significant bit first, one bit per active cycle, ten bits per word. The shift register reloads from the holding register on the active cycle after its tenth bit has been shifted. A bit at the shifter output shows on `sdo_o` after one more active edge. After a clear, ten zero bits are sent before the first held word.
- R2: A high `load_i` at a clock edge captures `word_i` into the holding register, whether or not the clock is locked. Without a new load, the held word is sent again and again.
- R3: With `scramble_en_i` high, each scrambled bit is s[n] = b[n] XOR s[n-4] XOR s[n-9], where b is the shifter bit and s is the scrambled history.
- R4: With `scramble_en_i` low, the shifter bit is passed on unchanged.
- R5: With `nrz_sel_i` low, the output is NRZI: each output bit is the incoming bit XOR the previous output bit. With `nrz_sel_i` high, the incoming bit is sent as is. This choice does not depend on `scramble_en_i`.
- R6: While `locked_i` is low and no flush is applied, no state advances and `sdo_o` holds its value.
- R7: A high `flush_i` at an edge clears the holding register, shifter, bit counter, scrambler history and NRZI state. `sdo_o` is 0 after that edge.
- R8: While `rst_n_i` is low, `sdo_o` is 0. After reset is released, the line stays 0 until a word is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit_i | input | 1 | Bit clock, ten times the word rate |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| locked_i | input | 1 | Clock source locked; all state advances only while this is high |
| flush_i | input | 1 | Synchronous clear of all state (new sync position) |
| load_i | input | 1 | Write strobe for the holding register |
| word_i | input | 10 | Parallel word to transmit |
| scramble_en_i | input | 1 | 1 = video mode with scrambling, 0 = scrambler bypassed |
| nrz_sel_i | input | 1 | 0 = NRZI coding, 1 = plain NRZ |
| sdo_o | output | 1 | Serial data out |

## Verification
The bench builds the block with its default parameters: a 10-bit word and scrambler taps at delays 4 and 9. Each stream is long enough that the scrambler history wraps past the far tap many times, so both tap positions affect the checked bits. All four combinations of scrambler and NRZI setting are covered. Some streams are broken up by periodic loss of lock, which puts word loads in cycles where the clock is unlocked and shows that the line holds still. One stream runs with no load after a flush, which shows at the line that the holding register was cleared.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int unsigned DEF_WORD_W   = 10;
  localparam int unsigned DEF_TAP_NEAR = 4;
  localparam int unsigned DEF_TAP_FAR  = 9;
endpackage

// File: rtl/ser_word_shifter.sv
module ser_word_shifter #(
  parameter int unsigned WORD_W = ser_pkg::DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] hold_q, hold_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    hold_d = hold_q;
    if (clear_i)     hold_d = '0;
    else if (load_i) hold_d = word_i;
  end

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (clear_i) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (step_i) begin
      if (cnt_q == LAST) begin
        sh_d  = hold_q;
        cnt_d = '0;
      end else begin
        sh_d  = {1'b0, sh_q[WORD_W-1:1]};
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else begin
      hold_q <= hold_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
    end
  end

  assign bit_o = sh_q[0];

  // R2: a strobe stores the presented word
  p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clear_i) |=> (hold_q == $past(word_i)));

  // R1: after the last bit of a word the shifter takes the held word
  p_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clear_i && cnt_q == LAST) |=> (sh_q == $past(hold_q)));
endmodule

// File: rtl/ser_scrambler.sv
module ser_scrambler #(
  parameter int unsigned TAP_NEAR = ser_pkg::DEF_TAP_NEAR,
  parameter int unsigned TAP_FAR  = ser_pkg::DEF_TAP_FAR
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic clear_i,
  input  logic enable_i,
  input  logic bit_i,
  output logic bit_o
);
  logic [TAP_FAR-1:0] hist_q, hist_d;

  always_comb begin
    if (enable_i) bit_o = bit_i ^ hist_q[TAP_NEAR-1] ^ hist_q[TAP_FAR-1];
    else          bit_o = bit_i;
  end

  always_comb begin
    hist_d = hist_q;
    if (clear_i)     hist_d = '0;
    else if (step_i) hist_d = {hist_q[TAP_FAR-2:0], bit_o};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  // R3: each emitted bit enters the history used by later taps
  p_hist_feed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clear_i) |=> (hist_q[0] == $past(bit_o)));
endmodule

// File: rtl/ser_line_coder.sv
module ser_line_coder (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic clear_i,
  input  logic nrz_i,
  input  logic bit_i,
  output logic line_o
);
  logic line_q, line_d;

  always_comb begin
    line_d = line_q;
    if (clear_i)     line_d = 1'b0;
    else if (step_i) line_d = nrz_i ? bit_i : (bit_i ^ line_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_d;
  end

  assign line_o = line_q;

  // R5: plain mode forwards the bit
  p_nrz_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clear_i && nrz_i) |=> (line_o == $past(bit_i)));

  // R5: NRZI mode toggles the line on a one
  p_nrzi_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clear_i && !nrz_i && bit_i) |=> (line_o != $past(line_o)));
endmodule

// File: rtl/sdi_bit_serializer.sv
module sdi_bit_serializer #(
  parameter int unsigned WORD_W   = ser_pkg::DEF_WORD_W,
  parameter int unsigned TAP_NEAR = ser_pkg::DEF_TAP_NEAR,
  parameter int unsigned TAP_FAR  = ser_pkg::DEF_TAP_FAR
) (
  input  logic              clk_bit_i,
  input  logic              rst_n_i,
  input  logic              locked_i,
  input  logic              flush_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              scramble_en_i,
  input  logic              nrz_sel_i,
  output logic              sdo_o
);
  logic rst_meta_q, rst_q;

  always_ff @(posedge clk_bit_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  logic raw_bit, scr_bit;

  ser_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk_bit_i),
    .rst_n   (rst_q),
    .step_i  (locked_i),
    .clear_i (flush_i),
    .load_i  (load_i),
    .word_i  (word_i),
    .bit_o   (raw_bit)
  );

  ser_scrambler #(.TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR)) u_scr (
    .clk      (clk_bit_i),
    .rst_n    (rst_q),
    .step_i   (locked_i),
    .clear_i  (flush_i),
    .enable_i (scramble_en_i),
    .bit_i    (raw_bit),
    .bit_o    (scr_bit)
  );

  ser_line_coder u_code (
    .clk     (clk_bit_i),
    .rst_n   (rst_q),
    .step_i  (locked_i),
    .clear_i (flush_i),
    .nrz_i   (nrz_sel_i),
    .bit_i   (scr_bit),
    .line_o  (sdo_o)
  );

  // R6: the line holds while the clock source is unlocked
  p_static_unlocked_r6: assert property (@(posedge clk_bit_i) disable iff (!rst_q)
    (!locked_i && !flush_i) |=> $stable(sdo_o));

  // R7: a flush drives the line low at the next edge
  p_flush_clear_r7: assert property (@(posedge clk_bit_i) disable iff (!rst_q)
    flush_i |=> !sdo_o);
endmodule

// File: tb/test_sdi_bit_serializer.sv
module test_sdi_bit_serializer;
  typedef struct {
    logic  v;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n, locked, flush, load, scr_en, nrz_sel;
  logic [9:0] word;
  logic       sdo;

  int   n_vec = 0;
  int   n_bad = 0;
  exp_t exp_q[$];
  logic armed = 1'b0;
  logic lk_prev = 1'b0;
  logic last_sdo = 1'b0;

  always #4 clk = ~clk;

  sdi_bit_serializer i_sdi_bit_serializer (
    .clk_bit_i     (clk),
    .rst_n_i       (rst_n),
    .locked_i      (locked),
    .flush_i       (flush),
    .load_i        (load),
    .word_i        (word),
    .scramble_en_i (scr_en),
    .nrz_sel_i     (nrz_sel),
    .sdo_o         (sdo)
  );

  always @(posedge clk) lk_prev <= locked;

  // monitor: pops one expected bit per locked edge, else checks a still line
  always @(negedge clk) begin
    if (armed) begin
      if (lk_prev) begin
        if (exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          n_vec++;
          if (sdo !== e.v) begin
            n_bad++;
            $display("FAIL %s: sdo=%0b expected %0b", e.tag, sdo, e.v);
          end
        end
      end else begin
        n_vec++;
        if (sdo !== last_sdo) begin
          n_bad++;
          $display("FAIL R6 unlocked line moved: sdo=%0b expected %0b", sdo, last_sdo);
        end
      end
      last_sdo = sdo;
    end
  end

  function automatic logic [9:0] gen_word(input int seed, input int i);
    int t;
    t = seed * 37 + i * 213 + ((i * 5) ^ seed);
    return t[9:0];
  endfunction

  task automatic direct_check(input string tag, input logic exp);
    @(negedge clk);
    n_vec++;
    if (sdo !== exp) begin
      n_bad++;
      $display("FAIL %s: sdo=%0b expected %0b", tag, sdo, exp);
    end
  endtask

  // driver: flush, push the expected stream, then feed words
  task automatic run_stream(input string tag, input logic scr, input logic nrz,
                            input int nwords, input int gap, input int seed);
    logic [9:0] w [0:31];
    logic [8:0] h;
    logic       o, b, s;
    int         raw_n, steps, cyc, ld_idx;
    exp_t       e;
    for (int i = 0; i < nwords; i++) w[i] = gen_word(seed, i);
    @(posedge clk); #1;
    scr_en = scr; nrz_sel = nrz; flush = 1'b1; locked = 1'b1; load = 1'b0;
    @(posedge clk); #1;
    flush = 1'b0;
    e.v = 1'b0; e.tag = "R7 flush clears line";
    exp_q.push_back(e);
    h = '0; o = 1'b0;
    raw_n = 10 * (nwords + 2);
    for (int k = 0; k < raw_n; k++) begin
      int wi;
      if (k < 10) b = 1'b0;
      else begin
        wi = (k - 10) / 10;
        if (wi >= nwords) wi = nwords - 1;
        b = (nwords == 0) ? 1'b0 : w[wi][(k - 10) % 10];
      end
      s = scr ? (b ^ h[3] ^ h[8]) : b;
      h = {h[7:0], s};
      o = nrz ? s : (s ^ o);
      e.v = o;
      e.tag = (k < 10) ? "R7 zero lead after flush" : tag;
      exp_q.push_back(e);
    end
    armed = 1'b1;
    steps = 0; cyc = 0; ld_idx = 0;
    while (exp_q.size() > 0) begin
      load = 1'b0;
      if (ld_idx < nwords && steps >= 10 * ld_idx) begin
        load = 1'b1;
        word = w[ld_idx];
        ld_idx++;
      end
      locked = !(gap != 0 && (cyc % gap) == gap - 1);
      @(posedge clk); #1;
      if (locked) steps++;
      cyc++;
    end
    armed = 1'b0;
    load = 1'b0;
    locked = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): run did not end, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; locked = 1'b1; flush = 1'b0; load = 1'b0;
    scr_en = 1'b0; nrz_sel = 1'b1; word = '0;
    // R8: line low during reset
    repeat (3) direct_check("R8 line during reset", 1'b0);
    @(posedge clk); #1 rst_n = 1'b1;
    // R8: line remains low after release with nothing loaded
    repeat (14) direct_check("R8 line after reset", 1'b0);

    // R1 R4: plain serializer, NRZ, bit order LSB first
    run_stream("R1/R4 plain NRZ stream", 1'b0, 1'b1, 6, 0, 3);
    // R3: scrambled, NRZ
    run_stream("R3 scrambled NRZ stream", 1'b1, 1'b1, 12, 0, 11);
    // R5: NRZI without scrambling
    run_stream("R5/R4 NRZI unscrambled stream", 1'b0, 1'b0, 8, 0, 29);
    // R3 R5: scrambled and NRZI together
    run_stream("R3/R5 scrambled NRZI stream", 1'b1, 1'b0, 12, 0, 57);
    // R7 R2: flush clears the holding register; no load gives zeros only
    run_stream("R7/R2 cleared hold no load", 1'b0, 1'b1, 0, 0, 0);
    // R6 R2: lock dropouts, loads landing in unlocked cycles
    run_stream("R6/R2 stream with lock gaps", 1'b1, 1'b0, 10, 4, 91);
    run_stream("R6 plain stream with lock gaps", 1'b0, 1'b1, 7, 3, 140);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule